// File: doc/BRIEF.md
# Burst Address Counter with Readback

This block produces the per-cycle word address for one port of a memory array. Each cycle, three active-low controls decide where the address comes from: a counter clear, an address strobe and a count enable. The address can be a new value taken from the external address bus. It can be the next sequential address from an internal counter, or it can be the counter's held value. Burst transfers therefore need one external address, followed by internally generated addresses for as long as counting stays enabled.

The block also supports reading back the counter. When the port is reading, the strobe is asserted and counting is disabled, the counter holds its value. In that cycle the port's data output carries the counter value in place of the memory's read data. The counter value sits at a fixed bit offset, and every other data bit is zero. The effective address `addr_int` always shows the location that the current cycle's access uses.

Top module: `burst_addr_gen`

## Requirements
- R1: When `cnt_clr_n` is low, the counter clears to zero at the clock edge, whatever `strobe_n` and `step_n` are. In the same cycle `addr_int` is zero, so an access that coincides with the clear goes to address zero.
- R2: With `cnt_clr_n` high, `strobe_n` low and `step_n` low, `addr_int` equals `ext_addr` in that cycle, and the counter takes that value at the edge.
- R3: With `cnt_clr_n` high, `strobe_n` high and `step_n` low, `addr_int` is the counter value plus one, and the counter takes that value at the edge.
- R4: With `cnt_clr_n`, `strobe_n` and `step_n` all high, the counter keeps its value and `addr_int` equals it; `ext_addr` has no effect.
- R5: With `cnt_clr_n` high, `strobe_n` low, `step_n` high and `rd_mode` high, the counter holds and `rb_sel` is high. `dout` carries the counter value on bits `RB_LSB` to `RB_LSB+ADDR_W-1` (bits 3 to 17 by default), with every other bit zero.
- R6: The same controls as R5 with `rd_mode` low hold the counter without readback: `rb_sel` is low and `dout` equals `mem_rdata`.
- R7: Incrementing from address `DEPTH-1` yields address zero.
- R8: `rst_n` low at a clock edge sets the counter to zero, whatever the other controls are.
- R9: In every cycle that is not a readback cycle, `dout` equals `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low system reset |
| ext_addr | input | ADDR_W | External address bus |
| strobe_n | input | 1 | Address strobe, active low |
| step_n | input | 1 | Count enable, active low |
| cnt_clr_n | input | 1 | Counter clear, active low, highest priority |
| rd_mode | input | 1 | 1 = current access is a read |
| mem_rdata | input | DATA_W | Read data from the memory array |
| addr_int | output | ADDR_W | Effective address of the current cycle |
| dout | output | DATA_W | Port read data, or the counter value during readback |
| rb_sel | output | 1 | High in a readback cycle |

## Verification
The bench drives a load followed by a run of increments. It then applies a hold with a changed external address, which separates a true hold from a pass-through of `ext_addr`. Readback is tried with `rd_mode` both high and low, which shows that the data mux switches only for reads. A clear is applied while the strobe and enable request a load and, in a second test, an increment, which confirms that the clear has priority. A load just below the top address, followed by increments, covers the wrap to zero. A system reset in the middle of the sequence confirms that the counter restarts from zero.

// File: rtl/burst_addr_pkg.sv
// Shared types for the burst address generator.
package burst_addr_pkg;
    // Counter operation selected for the current cycle
    typedef enum logic [2:0] {
        OP_CLEAR,
        OP_LOAD,
        OP_STEP,
        OP_HOLD,
        OP_READBACK
    } ctr_op_e;
endpackage

// File: rtl/ctr_op_decode.sv
// Decodes the active-low counter controls into one operation.
// Assumes: all inputs are sampled synchronously by the caller.
module ctr_op_decode
    import burst_addr_pkg::*;
(
    input  logic    strobe_n,
    input  logic    step_n,
    input  logic    cnt_clr_n,
    input  logic    rd_mode,
    output ctr_op_e op
);
    // Priority: clear, then the strobe/enable pair
    always_comb begin
        if (!cnt_clr_n)
            op = OP_CLEAR;
        else if (!strobe_n && !step_n)
            op = OP_LOAD;
        else if (strobe_n && !step_n)
            op = OP_STEP;
        else if (!strobe_n && rd_mode)
            op = OP_READBACK;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/ctr_core.sv
// Holds the address counter and computes the effective address.
// Assumes: DEPTH <= 2**ADDR_W; addr_int is the value the counter takes
// at the coming edge, i.e. the location used by this cycle's access.
module ctr_core
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DEPTH  = 2 ** ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctr_op_e           op,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] addr_int,
    output logic [ADDR_W-1:0] cnt_q
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] cnt_d;

    // Next counter value per operation, with wrap at the last word
    always_comb begin
        unique case (op)
            OP_CLEAR: cnt_d = '0;
            OP_LOAD:  cnt_d = ext_addr;
            OP_STEP:  cnt_d = (cnt_q == LAST) ? '0 : cnt_q + ADDR_W'(1);
            default:  cnt_d = cnt_q;
        endcase
    end

    // Counter register with synchronous system reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // Effective address of the current access
    assign addr_int = cnt_d;

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR) |=> (cnt_q == '0));
    // R2
    load_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (cnt_q == $past(ext_addr)));
    // R3
    step_plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + ADDR_W'(1)));
    // R7
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP && cnt_q == LAST) |=> (cnt_q == '0));
    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD || op == OP_READBACK) |=> $stable(cnt_q));
endmodule

// File: rtl/rb_mux.sv
// Selects between memory read data and the counter readback image.
// Assumes: DATA_W >= RB_LSB + ADDR_W.
module rb_mux #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 36,
    parameter int RB_LSB = 3
) (
    input  logic [ADDR_W-1:0] cnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              rb_sel,
    output logic [DATA_W-1:0] dout
);
    // Readback image: counter at RB_LSB, zeros elsewhere
    always_comb begin
        dout = mem_rdata;
        if (rb_sel) begin
            dout = '0;
            dout[RB_LSB +: ADDR_W] = cnt;
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Per-port burst address generator with counter readback.
// Assumes: one clock domain; rst_n is synchronous and active low.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 36,
    parameter int RB_LSB = 3,
    parameter int DEPTH  = 2 ** ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_n,
    input  logic              step_n,
    input  logic              cnt_clr_n,
    input  logic              rd_mode,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] addr_int,
    output logic [DATA_W-1:0] dout,
    output logic              rb_sel
);
    ctr_op_e           op;
    logic [ADDR_W-1:0] cnt_q;

    ctr_op_decode u_dec (
        .strobe_n  (strobe_n),
        .step_n    (step_n),
        .cnt_clr_n (cnt_clr_n),
        .rd_mode   (rd_mode),
        .op        (op)
    );

    ctr_core #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .ext_addr (ext_addr),
        .addr_int (addr_int),
        .cnt_q    (cnt_q)
    );

    // Readback only in a read cycle with strobe low and enable high
    assign rb_sel = (op == OP_READBACK);

    rb_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RB_LSB(RB_LSB)) u_mux (
        .cnt       (cnt_q),
        .mem_rdata (mem_rdata),
        .rb_sel    (rb_sel),
        .dout      (dout)
    );

    // R5
    rb_image_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_sel |-> (dout[RB_LSB +: ADDR_W] == cnt_q && addr_int == cnt_q));
    // R9
    pass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_sel |-> (dout == mem_rdata));
    // R8
    sys_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0));
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 15;
    localparam int DW = 36;

    typedef struct {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          rb;
        string         tag;
    } exp_t;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [AW-1:0] ext_addr = '0;
    logic          strobe_n = 1, step_n = 1, cnt_clr_n = 1, rd_mode = 0;
    logic [DW-1:0] mem_rdata = '0;
    logic [AW-1:0] addr_int;
    logic [DW-1:0] dout;
    logic          rb_sel;

    exp_t          sb[$];
    logic [AW-1:0] mdl = '0;
    int            n_chk = 0, n_bad = 0;
    bit            done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .strobe_n(strobe_n),
        .step_n(step_n), .cnt_clr_n(cnt_clr_n), .rd_mode(rd_mode),
        .mem_rdata(mem_rdata), .addr_int(addr_int), .dout(dout), .rb_sel(rb_sel)
    );

    // Driver: applies one cycle, pushes the expected outputs, updates the model
    task automatic step(input logic sys, input logic clr, input logic stb,
                        input logic en, input logic rd, input logic [AW-1:0] ea,
                        input logic [DW-1:0] md, input string tag);
        logic [AW-1:0] nxt;
        logic          rb;
        exp_t          e;
        @(negedge clk);
        rst_n = sys; cnt_clr_n = clr; strobe_n = stb; step_n = en;
        rd_mode = rd; ext_addr = ea; mem_rdata = md;
        if (!clr)             nxt = '0;
        else if (!stb && !en) nxt = ea;
        else if (stb && !en)  nxt = (mdl == {AW{1'b1}}) ? '0 : mdl + 1'b1;
        else                  nxt = mdl;
        rb = clr && !stb && en && rd;
        if (sys) begin
            e.addr = nxt;
            e.data = rb ? ({{(DW-AW){1'b0}}, mdl} << 3) : md;
            e.rb   = rb;
            e.tag  = tag;
            sb.push_back(e);
        end
        @(posedge clk);
        mdl = sys ? nxt : '0;
    endtask

    // Monitor: compares outputs away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (addr_int !== e.addr || dout !== e.data || rb_sel !== e.rb) begin
                    n_bad++;
                    $display("FAIL %s: addr=%h dout=%h rb=%b expected addr=%h dout=%h rb=%b",
                             e.tag, addr_int, dout, rb_sel, e.addr, e.data, e.rb);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        step(0, 1, 1, 1, 0, 15'h0, 36'h0, "R8 reset");
        step(0, 1, 1, 1, 0, 15'h0, 36'h0, "R8 reset");
        step(1, 1, 1, 1, 0, 15'h2222, 36'h1_2345_6789, "R8 R9 reset state");
        step(1, 1, 0, 0, 1, 15'h1234, 36'hA_AAAA_AAAA, "R2 load");
        step(1, 1, 1, 0, 1, 15'h0111, 36'h5_5555_5555, "R3 step 1");
        step(1, 1, 1, 0, 0, 15'h0222, 36'h0_0000_0001, "R3 step 2");
        step(1, 1, 1, 0, 1, 15'h0333, 36'hF_0000_000F, "R3 step 3");
        step(1, 1, 1, 1, 1, 15'h7ABC, 36'h3_3333_3333, "R4 hold blocks ext");
        step(1, 1, 0, 1, 1, 15'h0444, 36'hF_FFFF_FFFF, "R5 readback");
        step(1, 1, 0, 1, 0, 15'h0555, 36'h9_8765_4321, "R6 no readback on write");
        step(1, 0, 0, 0, 1, 15'h0666, 36'h1_1111_1111, "R1 clear over load");
        step(1, 1, 1, 1, 1, 15'h0777, 36'h2_2222_2222, "R1 hold after clear");
        step(1, 1, 0, 0, 1, 15'h0040, 36'h0, "R2 load 0x40");
        step(1, 0, 1, 0, 1, 15'h0888, 36'h4_4444_4444, "R1 clear over step");
        step(1, 1, 0, 0, 1, 15'h7FFE, 36'h6_6666_6666, "R2 load near top");
        step(1, 1, 1, 0, 1, 15'h0, 36'h7_7777_7777, "R3 step to top");
        step(1, 1, 1, 0, 1, 15'h0, 36'h8_8888_8888, "R7 wrap to zero");
        step(1, 1, 1, 0, 1, 15'h0, 36'h9_9999_9999, "R7 step after wrap");
        step(1, 1, 0, 1, 1, 15'h0, 36'hF_FFFF_FFFF, "R5 readback after wrap");
        step(1, 1, 0, 0, 1, 15'h0055, 36'h0, "R2 load before sys reset");
        step(0, 1, 0, 0, 1, 15'h0066, 36'h0, "R8 mid reset");
        step(1, 1, 1, 1, 1, 15'h0077, 36'hB_BBBB_BBBB, "R8 counter zero after reset");
        @(negedge clk);
        @(negedge clk);
        #3;
        n_chk++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R9 scoreboard drain: %0d left, expected 0", sb.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule